// File: doc/BRIEF.md
# Hex Status Message Formatter

This block turns progress events from a memory self-test into lines of ASCII text and hands the text out one byte at a time to a serial transmitter. The transmitter runs at 115200 bps. The event source presents one event on an event port, with a kind code and the values that go with it. The formatter captures the event and prints every numeric value as lowercase hexadecimal of fixed width, most significant nibble first. It then sends the whole message over a valid/ready byte handshake.

While a message is going out, `busy` is high. The event source must wait for `busy` to be low before it offers the next event. An event offered while the formatter is busy is dropped, and so is an event with an unknown kind code. Right after reset, the formatter prints a one-time title line without being asked.

Top module: `hexmsg_formatter`

## Requirements
- R1: After reset, `busy` and `tx_valid` are high and the first byte is 'R' (0x52). The formatter sends the 8 bytes "RAM Test" once, without any event.
- R2: Kind code 0 (round start) sends CR (0x0D), LF (0x0A), "R=", 4 digits of `ev_round`, " F=", and 8 digits of `ev_faults`.
- R3: Kind code 1 (pattern start) sends CR, LF, "P=", and 4 digits of `ev_pattern`.
- R4: Kind code 2 (burst start) sends " B=" and 3 digits of `ev_burst`, with no line break.
- R5: Kind code 3 (fault total) sends " F=" and 8 digits of `ev_faults`, with no line break.
- R6: Kind code 4 (error record) sends CR, LF, "E=", then the following fields separated by '-': 1 digit of `ev_err_elem`, 6 digits of `ev_err_addr`, 1 digit of `ev_err_mask`, 4 digits of `ev_err_expect`, and 4 digits of `ev_err_actual`.
- R7: Each hex digit is '0'..'9' (0x30..0x39) or 'a'..'f' (0x61..0x66). The digits of a field go out most significant nibble first.
- R8: `tx_valid` equals `busy`. A byte moves on only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` holds its value.
- R9: An event offered while `busy` is high is ignored. Kind codes 5, 6 and 7 are ignored, and `busy` stays low in the next cycle.
- R10: An event with a valid kind code is accepted in a cycle where `busy` is low. Its first byte is presented in the next cycle. `busy` falls in the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered this cycle |
| ev_kind | input | 3 | Event kind code (0 round, 1 pattern, 2 burst, 3 fault total, 4 error) |
| ev_round | input | 16 | Round counter value |
| ev_faults | input | 32 | Fault total, used by kinds 0 and 3 |
| ev_pattern | input | 16 | Test pattern value |
| ev_burst | input | 12 | Burst length |
| ev_err_elem | input | 1 | Error: march element flag |
| ev_err_addr | input | 24 | Error: word address |
| ev_err_mask | input | 4 | Error: byte mask |
| ev_err_expect | input | 16 | Error: expected data |
| ev_err_actual | input | 16 | Error: data read back |
| busy | output | 1 | A message is being sent |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter takes the byte |

## Verification
Two things can fall on the same clock edge. The last byte of a message can be accepted on the edge where a new event is being offered. An event can also arrive while a message is still going out. The bench provokes the first case by issuing the next event in the very cycle `busy` is first seen low, through runs of back-to-back bursts. It provokes the second by offering an event one cycle after another one was accepted. A reference queue of expected bytes, and an expected `busy` derived from that queue, are compared in every cycle under three `tx_ready` patterns. A dropped event that the design took anyway therefore shows up as extra bytes or a wrong `busy` level.

// File: rtl/hexfmt_pkg.sv
package hexfmt_pkg;
  localparam int ROUND_W = 16;
  localparam int FAULT_W = 32;
  localparam int PAT_W   = 16;
  localparam int BURST_W = 12;
  localparam int ADDR_W  = 24;
  localparam int MASK_W  = 4;
  localparam int DATA_W  = 16;

  localparam int RD = ROUND_W / 4;
  localparam int FD = FAULT_W / 4;
  localparam int PD = PAT_W / 4;
  localparam int BD = BURST_W / 4;
  localparam int AD = ADDR_W / 4;
  localparam int MD = MASK_W / 4;
  localparam int DD = DATA_W / 4;

  localparam int ERR_NIB   = 1 + AD + MD + 2 * DD;
  localparam int ROUND_NIB = RD + FD;
  localparam int PAY_NIB   = (ERR_NIB > ROUND_NIB) ? ERR_NIB : ROUND_NIB;
  localparam int PAY_W     = 4 * PAY_NIB;

  localparam int LEN_BANNER = 8;
  localparam int LEN_ROUND  = 4 + RD + 3 + FD;
  localparam int LEN_PAT    = 4 + PD;
  localparam int LEN_BURST  = 3 + BD;
  localparam int LEN_FAULT  = 3 + FD;
  localparam int LEN_ERR    = 4 + ERR_NIB + 4;
  localparam int MAX_LEN    = (LEN_ERR > LEN_ROUND) ? LEN_ERR : LEN_ROUND;
  localparam int IDX_W      = $clog2(MAX_LEN + 1);

  localparam logic [63:0] BANNER_TXT = 64'h52414D2054657374;

  // error record dash positions, counted after the leading "\r\nE="
  localparam int DASH1 = 1;
  localparam int DASH2 = DASH1 + AD + 1;
  localparam int DASH3 = DASH2 + MD + 1;
  localparam int DASH4 = DASH3 + DD + 1;

  typedef enum logic [2:0] {
    K_ROUND  = 3'd0,
    K_PAT    = 3'd1,
    K_BURST  = 3'd2,
    K_FAULT  = 3'd3,
    K_ERR    = 3'd4,
    K_BANNER = 3'd7
  } kind_e;

  typedef logic [PAY_W-1:0] payload_t;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
  endfunction

  function automatic logic [3:0] nib(input payload_t p, input int n);
    payload_t t;
    t = p >> (4 * n);
    return t[3:0];
  endfunction

  function automatic logic [IDX_W-1:0] msg_len(input kind_e k);
    int n;
    case (k)
      K_ROUND: n = LEN_ROUND;
      K_PAT:   n = LEN_PAT;
      K_BURST: n = LEN_BURST;
      K_FAULT: n = LEN_FAULT;
      K_ERR:   n = LEN_ERR;
      default: n = LEN_BANNER;
    endcase
    return IDX_W'(n);
  endfunction

  function automatic payload_t pack_payload(
      input kind_e k, input logic [ROUND_W-1:0] rnd, input logic [FAULT_W-1:0] flt,
      input logic [PAT_W-1:0] pat, input logic [BURST_W-1:0] bst, input logic elem,
      input logic [ADDR_W-1:0] addr, input logic [MASK_W-1:0] mask,
      input logic [DATA_W-1:0] expd, input logic [DATA_W-1:0] actd);
    payload_t p;
    p = '0;
    case (k)
      K_ROUND: begin
        p[FAULT_W-1:0]          = flt;
        p[FAULT_W +: ROUND_W]   = rnd;
      end
      K_PAT:   p[PAT_W-1:0]   = pat;
      K_BURST: p[BURST_W-1:0] = bst;
      K_FAULT: p[FAULT_W-1:0] = flt;
      K_ERR: begin
        p[DATA_W-1:0]                         = actd;
        p[DATA_W +: DATA_W]                   = expd;
        p[2*DATA_W +: MASK_W]                 = mask;
        p[2*DATA_W+MASK_W +: ADDR_W]          = addr;
        p[2*DATA_W+MASK_W+ADDR_W]             = elem;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic logic [7:0] msg_char(input kind_e k, input int idx, input payload_t p);
    int j;
    int dashes;
    logic [7:0] c;
    j = idx - 4;
    c = 8'h3F;
    case (k)
      K_BANNER: c = BANNER_TXT[8*(LEN_BANNER-1-idx) +: 8];
      K_ROUND, K_PAT, K_ERR: begin
        if (idx == 0)      c = 8'h0D;
        else if (idx == 1) c = 8'h0A;
        else if (idx == 2) c = (k == K_ROUND) ? 8'h52 : (k == K_PAT) ? 8'h50 : 8'h45;
        else if (idx == 3) c = 8'h3D;
        else if (k == K_PAT) c = hex_char(nib(p, PD - 1 - j));
        else if (k == K_ROUND) begin
          if (j < RD)            c = hex_char(nib(p, RD + FD - 1 - j));
          else if (j == RD)      c = 8'h20;
          else if (j == RD + 1)  c = 8'h46;
          else if (j == RD + 2)  c = 8'h3D;
          else                   c = hex_char(nib(p, FD - 1 - (j - RD - 3)));
        end else begin
          if (j == DASH1 || j == DASH2 || j == DASH3 || j == DASH4) c = 8'h2D;
          else begin
            dashes = (j > DASH1 ? 1 : 0) + (j > DASH2 ? 1 : 0) +
                     (j > DASH3 ? 1 : 0) + (j > DASH4 ? 1 : 0);
            c = hex_char(nib(p, ERR_NIB - 1 - (j - dashes)));
          end
        end
      end
      K_BURST, K_FAULT: begin
        if (idx == 0)      c = 8'h20;
        else if (idx == 1) c = (k == K_BURST) ? 8'h42 : 8'h46;
        else if (idx == 2) c = 8'h3D;
        else               c = hex_char(nib(p, ((k == K_BURST) ? BD : FD) - 1 - (idx - 3)));
      end
      default: c = 8'h3F;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fmt_capture.sv
module fmt_capture
  import hexfmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     busy,
  input  kind_e    kind_in,
  input  payload_t pay_in,
  output kind_e    kind_q,
  output payload_t pay_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_BANNER;
      pay_q  <= '0;
    end else if (load) begin
      kind_q <= kind_in;
      pay_q  <= pay_in;
    end
  end

  // R9: a message in flight keeps its captured event
  p_hold_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(kind_q) && $stable(pay_q));
endmodule

// File: rtl/fmt_stepper.sv
module fmt_stepper
  import hexfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fire,
  input  logic [IDX_W-1:0] len,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  assign last = busy && (idx == len - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx < len);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last |=> !busy);
  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && idx == '0);
endmodule

// File: rtl/fmt_charsel.sv
module fmt_charsel
  import hexfmt_pkg::*;
(
  input  kind_e            kind,
  input  logic [IDX_W-1:0] idx,
  input  payload_t         pay,
  output logic [7:0]       ch
);
  always_comb ch = msg_char(kind, int'(idx), pay);
endmodule

// File: rtl/hexmsg_formatter.sv
module hexmsg_formatter
  import hexfmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [2:0]         ev_kind,
  input  logic [ROUND_W-1:0] ev_round,
  input  logic [FAULT_W-1:0] ev_faults,
  input  logic [PAT_W-1:0]   ev_pattern,
  input  logic [BURST_W-1:0] ev_burst,
  input  logic               ev_err_elem,
  input  logic [ADDR_W-1:0]  ev_err_addr,
  input  logic [MASK_W-1:0]  ev_err_mask,
  input  logic [DATA_W-1:0]  ev_err_expect,
  input  logic [DATA_W-1:0]  ev_err_actual,
  output logic               busy,
  output logic [7:0]         tx_data,
  output logic               tx_valid,
  input  logic               tx_ready
);
  logic             accept;
  logic             fire;
  logic             last;
  kind_e            kind_q;
  payload_t         pay_in;
  payload_t         pay_q;
  logic [IDX_W-1:0] len;
  logic [IDX_W-1:0] idx;

  assign accept   = ev_valid && !busy && kind_ok(ev_kind);
  assign fire     = tx_valid && tx_ready;
  assign tx_valid = busy;
  assign len      = msg_len(kind_q);
  assign pay_in   = pack_payload(kind_e'(ev_kind), ev_round, ev_faults, ev_pattern, ev_burst,
                                 ev_err_elem, ev_err_addr, ev_err_mask, ev_err_expect,
                                 ev_err_actual);

  fmt_capture i_capture (
    .clk(clk), .rst_n(rst_n), .load(accept), .busy(busy),
    .kind_in(kind_e'(ev_kind)), .pay_in(pay_in), .kind_q(kind_q), .pay_q(pay_q)
  );

  fmt_stepper i_stepper (
    .clk(clk), .rst_n(rst_n), .start(accept), .fire(fire), .len(len),
    .busy(busy), .idx(idx), .last(last)
  );

  fmt_charsel i_charsel (.kind(kind_q), .idx(idx), .pay(pay_q), .ch(tx_data));

  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_legal_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == 8'h0D || tx_data == 8'h0A ||
                  (tx_data >= 8'h20 && tx_data <= 8'h7E)));
  p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !accept |=> !busy);
endmodule

// File: tb/test_hexmsg_formatter.sv
`timescale 1ns/1ps
module test_hexmsg_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic [15:0] ev_round = '0;
  logic [31:0] ev_faults = '0;
  logic [15:0] ev_pattern = '0;
  logic [11:0] ev_burst = '0;
  logic        ev_err_elem = 1'b0;
  logic [23:0] ev_err_addr = '0;
  logic [3:0]  ev_err_mask = '0;
  logic [15:0] ev_err_expect = '0;
  logic [15:0] ev_err_actual = '0;
  logic        busy;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  hexmsg_formatter i_hexmsg_formatter (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_round(ev_round), .ev_faults(ev_faults), .ev_pattern(ev_pattern),
    .ev_burst(ev_burst), .ev_err_elem(ev_err_elem), .ev_err_addr(ev_err_addr),
    .ev_err_mask(ev_err_mask), .ev_err_expect(ev_err_expect),
    .ev_err_actual(ev_err_actual), .busy(busy), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  always #2.5 clk = ~clk;

  logic [7:0] exp_q[$];
  string      req_q[$];
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;
  int         ready_mode = 0;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  localparam int WATCHDOG = 100000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic tick();
    bit r;
    logic [7:0] e;
    string rq;
    @(negedge clk);
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
    ev_valid = 1'b0;
    chk(busy == (exp_q.size() != 0), "R10", "busy level", busy, exp_q.size() != 0);
    chk(tx_valid == busy, "R8", "tx_valid vs busy", tx_valid, busy);
    if (prev_stall) chk(tx_data == prev_data, "R8", "byte held under stall", tx_data, prev_data);
    case (ready_mode)
      0: r = 1'b1;
      1: r = ($urandom % 2) == 0;
      default: r = (cyc % 3) == 0;
    endcase
    tx_ready = r;
    if (tx_valid && r && exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      rq = req_q.pop_front();
      chk(tx_data == e, rq, "byte", tx_data, e);
    end
    prev_stall = tx_valid && !r;
    prev_data  = tx_data;
  endtask

  task automatic push_text(input string s, input string req);
    for (int i = 0; i < s.len(); i++) begin
      exp_q.push_back(s[i]);
      req_q.push_back(req);
    end
  endtask

  task automatic offer(input logic [2:0] k, input string s, input string req);
    ev_kind  = k;
    ev_valid = 1'b1;
    if (!busy && k <= 3'd4) push_text(s, req);
  endtask

  task automatic ev_round_t(input logic [15:0] r, input logic [31:0] f, input string req);
    ev_round = r; ev_faults = f;
    offer(3'd0, $sformatf("\015\012R=%h F=%h", r, f), req);
  endtask

  task automatic ev_pat_t(input logic [15:0] p, input string req);
    ev_pattern = p;
    offer(3'd1, $sformatf("\015\012P=%h", p), req);
  endtask

  task automatic ev_burst_t(input logic [11:0] b, input string req);
    ev_burst = b;
    offer(3'd2, $sformatf(" B=%h", b), req);
  endtask

  task automatic ev_fault_t(input logic [31:0] f, input string req);
    ev_faults = f;
    offer(3'd3, $sformatf(" F=%h", f), req);
  endtask

  task automatic ev_err_t(input logic a, input logic [23:0] ad, input logic [3:0] m,
                          input logic [15:0] ex, input logic [15:0] ac, input string req);
    ev_err_elem = a; ev_err_addr = ad; ev_err_mask = m;
    ev_err_expect = ex; ev_err_actual = ac;
    offer(3'd4, $sformatf("\015\012E=%h-%h-%h-%h-%h", a, ad, m, ex, ac), req);
  endtask

  task automatic wait_idle();
    do tick(); while (busy || exp_q.size() != 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state, banner begins without any event
    rst_n = 1'b1;
    #0.1;
    chk(busy == 1'b1, "R1", "busy after reset", busy, 1);
    chk(tx_valid == 1'b1, "R1", "tx_valid after reset", tx_valid, 1);
    chk(tx_data == 8'h52, "R1", "first banner byte", tx_data, 8'h52);
    push_text("RAM Test", "R1");
    ready_mode = 1;
    wait_idle();

    // R2..R5 with the transmitter always ready
    ready_mode = 0;
    ev_round_t(16'h0000, 32'h00000000, "R2"); wait_idle();
    ev_pat_t(16'hff00, "R3"); wait_idle();
    ev_burst_t(12'h001, "R4"); wait_idle();
    ev_burst_t(12'h03f, "R4"); wait_idle();
    ev_burst_t(12'h200, "R4"); wait_idle();
    ev_fault_t(32'h00000000, "R5"); wait_idle();

    // R6 under random stalls (R8)
    ready_mode = 1;
    ev_err_t(1'b1, 24'habcdef, 4'ha, 16'h1234, 16'hfedc, "R6"); wait_idle();
    ev_err_t(1'b0, 24'h000000, 4'h0, 16'h0000, 16'hffff, "R6"); wait_idle();

    // R7: every digit value, order of nibbles
    ev_pat_t(16'h0123, "R7"); wait_idle();
    ev_pat_t(16'h4567, "R7"); wait_idle();
    ev_pat_t(16'h89ab, "R7"); wait_idle();
    ev_pat_t(16'hcdef, "R7"); wait_idle();
    ev_round_t(16'hffff, 32'hdeadbeef, "R7"); wait_idle();
    ev_fault_t(32'h01234567, "R7"); wait_idle();

    // R9: event offered while busy is dropped
    ev_round_t(16'h0001, 32'h00000010, "R9");
    tick();
    ev_pat_t(16'h1111, "R9");
    tick();
    ev_fault_t(32'h22222222, "R9");
    wait_idle();
    // R9: unknown kind codes leave the formatter idle
    for (int k = 5; k < 8; k++) begin
      offer(3'(k), "", "R9");
      tick();
      chk(busy == 1'b0, "R9", "busy after unknown kind", busy, 0);
    end

    // R10: next event offered in the first idle cycle
    ready_mode = 0;
    ev_burst_t(12'h001, "R10");
    for (int b = 2; b <= 6; b++) begin
      do tick(); while (busy);
      ev_burst_t(12'(b), "R10");
    end
    wait_idle();

    // R8: sparse ready pattern over long messages
    ready_mode = 2;
    ev_round_t(16'h00a5, 32'h5a5a0f0f, "R8"); wait_idle();
    ev_err_t(1'b1, 24'h123456, 4'hc, 16'hbeef, 16'h0bad, "R8"); wait_idle();

    repeat (3) tick();
    finish_run();
  end
endmodule